// File: doc/BRIEF.md
# GPIO Register Bank with Bit-Alias Writes

This block holds the software-visible state of a 16-bit general-purpose I/O port. The state is eight registers: the port value, two interrupt enable masks (A and B), and the direction, polarity, edge-select, dual-edge and input-enable words. The port value and each mask also have three alias addresses. A write to an alias clears, sets or flips only the bits that are 1 in the written word. Software can therefore change single bits without a read-modify-write sequence.

Access is through a simple synchronous register bus. A request is presented for one cycle, and exactly one cycle later a response returns read data or flags an error. The bus has no back-pressure: the block accepts every request in the cycle it is presented. A separate pin-event port carries sampled pad levels into the port value, one pin per cycle. A pin is only accepted when it is configured as an input and its input is enabled.

Top module: `gpio_reg_bank`

## Requirements
- R1: After reset every register reads as 0x0000 and `rsp_valid` is low until a request is made.
- R2: A 16-bit write to a base register at byte offsets 0x00 (port value), 0x10 (mask A), 0x20 (mask B), 0x30 (direction), 0x34 (polarity), 0x38 (edge), 0x3C (dual-edge) or 0x40 (input enable) replaces its contents. A later read at that offset returns the written word.
- R3: A write to a clear alias (port value +0x04, mask A 0x14, mask B 0x24) sets to 0 every base-register bit that is 1 in the write data. All other bits are left unchanged.
- R4: A write to a set alias (0x08, 0x18, 0x28) ORs the write data into the base register.
- R5: A write to a toggle alias (0x0C, 0x1C, 0x2C) XORs the write data into the base register.
- R6: A read at any alias address returns the current value of its base register.
- R7: An access whose `req_size` is not 1 (encoding: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit), or whose address is not a multiple of 4, gets a response with `rsp_err` high and `rsp_rdata` 0. It changes no register.
- R8: An access at a word-aligned offset above 0x40 gets an error response and changes no register.
- R9: Every request gets a response with `rsp_valid` high in the cycle after it is presented, and in no other cycle. Writes return `rsp_rdata` 0. Register writes are visible to a read in the next cycle.
- R10: A pin event (`pin_valid` with `pin_idx` and `pin_level`) loads `pin_level` into that bit of the port value one cycle later. This happens only when the pin's direction bit is 0 and its input-enable bit is 1.
- R11: A pin event on a pin whose direction bit is 1 or whose input-enable bit is 0 leaves the port value unchanged.
- R12: If a pin event and a bus write to the port value or any of its aliases happen in the same cycle, the bus write alone determines the new port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset into the register map |
| req_size | input | 2 | Access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Response flags an illegal access |
| rsp_rdata | output | 16 | Read data (0 on writes and errors) |
| pin_valid | input | 1 | Pin-side level update present |
| pin_idx | input | 4 | Pin number of the update |
| pin_level | input | 1 | Sampled level of that pin |

## Verification
The hardest case to reach from the ports is a pin event and a bus write to the port-value group arriving in the same clock. One is an ordinary register write and the other is a pad-side update, so separate directed sequences never line them up. The collision task therefore drives the bus request and the pin event on the same falling edge. It does this once with a plain write and once with a set-alias write. It then reads the port value back to confirm the pin level was discarded. Gating by direction and input enable is reached by first programming those registers over the bus and then sending pin events at the blocked bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int SLOT_COUNT  = 17;
  localparam int ALIAS_SLOTS = 12;
  localparam int GROUP_COUNT = 8;
  localparam logic [1:0] SIZE_HALF = 2'd1;

  typedef enum logic [2:0] {
    GRP_DATA, GRP_MASKA, GRP_MASKB, GRP_DIR,
    GRP_POLAR, GRP_EDGE, GRP_BOTH, GRP_INEN
  } grp_e;

  typedef enum logic [1:0] {
    OP_WRITE, OP_CLEAR, OP_SET, OP_TOGGLE
  } op_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              ok,
  output grp_e              grp,
  output op_e               op
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] plain_off;

  assign idx       = addr[ADDR_W-1:2];
  assign plain_off = idx - IDX_W'(ALIAS_SLOTS - 3);

  always_comb begin
    ok  = (size == SIZE_HALF) && (addr[1:0] == 2'b00) && (idx < IDX_W'(SLOT_COUNT));
    grp = GRP_DATA;
    op  = OP_WRITE;
    if (idx < IDX_W'(ALIAS_SLOTS)) begin
      grp = grp_e'({1'b0, idx[3:2]});
      op  = op_e'(idx[1:0]);
    end else if (ok) begin
      grp = grp_e'(plain_off[2:0]);
    end
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  op_e          bus_op,
  input  logic [W-1:0] bus_wdata,
  input  logic         pin_we,
  input  logic [W-1:0] pin_sel,
  input  logic         pin_level,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (bus_we) begin
      unique case (bus_op)
        OP_WRITE:  q_next = bus_wdata;
        OP_CLEAR:  q_next = q & ~bus_wdata;
        OP_SET:    q_next = q | bus_wdata;
        OP_TOGGLE: q_next = q ^ bus_wdata;
        default:   q_next = q;
      endcase
    end else if (pin_we) begin
      q_next = (q & ~pin_sel) | (pin_level ? pin_sel : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_op == OP_CLEAR) |=> ((q & $past(bus_wdata)) == '0));
  assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_op == OP_SET) |=> ((q & $past(bus_wdata)) == $past(bus_wdata)));
  assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_op == OP_TOGGLE) |=> ((q ^ $past(q)) == $past(bus_wdata)));
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !pin_we) |=> $stable(q));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int PIN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              pin_valid,
  input  logic [PIN_W-1:0]  pin_idx,
  input  logic              pin_level
);
  logic acc_ok;
  grp_e acc_grp;
  op_e  acc_op;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .ok   (acc_ok),
    .grp  (acc_grp),
    .op   (acc_op)
  );

  logic [DATA_W-1:0] grp_q [GROUP_COUNT];
  logic [GROUP_COUNT*DATA_W-1:0] all_q;
  logic [DATA_W-1:0] dir_q, inen_q, data_q;
  logic [DATA_W-1:0] pin_sel;
  logic              pin_hit;
  logic              data_bus_we;

  assign dir_q   = grp_q[GRP_DIR];
  assign inen_q  = grp_q[GRP_INEN];
  assign data_q  = grp_q[GRP_DATA];
  assign pin_sel = DATA_W'(1) << pin_idx;
  assign pin_hit = pin_valid && !dir_q[pin_idx] && inen_q[pin_idx];
  assign data_bus_we = req_valid && req_write && acc_ok && (acc_grp == GRP_DATA);

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_reg
    logic bus_we_g;
    logic pin_we_g;
    assign bus_we_g = req_valid && req_write && acc_ok && (acc_grp == grp_e'(g));
    if (g == int'(GRP_DATA)) begin : g_pin
      assign pin_we_g = pin_hit;
    end else begin : g_nopin
      assign pin_we_g = 1'b0;
    end
    gpio_alias_reg #(.W(DATA_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we_g),
      .bus_op    (acc_op),
      .bus_wdata (req_wdata),
      .pin_we    (pin_we_g),
      .pin_sel   (pin_sel),
      .pin_level (pin_level),
      .q         (grp_q[g])
    );
    assign all_q[g*DATA_W +: DATA_W] = grp_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && acc_ok && !req_write) ? grp_q[acc_grp] : '0;
    end
  end

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok && !pin_valid) |=> $stable(all_q));
  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  assert_pin_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_hit && !data_bus_we) |=> (data_q[$past(pin_idx)] == $past(pin_level)));
  assert_pin_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && (dir_q[pin_idx] || !inen_q[pin_idx]) && !data_bus_we) |=> $stable(data_q));
  assert_bus_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && data_bus_we && acc_op == OP_WRITE) |=> (data_q == $past(req_wdata)));
endmodule

// File: tb/gpio_reg_bank_test.sv
`timescale 1ns/1ps
module gpio_reg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd1;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        pin_valid = 1'b0, pin_level = 1'b0;
  logic [3:0]  pin_idx = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_reg_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pin_valid(pin_valid), .pin_idx(pin_idx), .pin_level(pin_level)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [1:0] size,
                        input logic [15:0] wdata, output logic [15:0] rdata, output logic err,
                        output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wdata;
    @(negedge clk);
    rdata = rsp_rdata; err = rsp_err; vld = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr16(input logic [7:0] addr, input logic [15:0] v);
    logic [15:0] d; logic e, vl;
    access(1'b1, addr, 2'd1, v, d, e, vl);
  endtask

  task automatic rd16(input logic [7:0] addr, output logic [15:0] v);
    logic e, vl;
    access(1'b0, addr, 2'd1, 16'h0, v, e, vl);
  endtask

  task automatic pin_event(input logic [3:0] idx, input logic lvl);
    @(negedge clk);
    pin_valid = 1'b1; pin_idx = idx; pin_level = lvl;
    @(negedge clk);
    pin_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 rsp_valid idle", rsp_valid, 0);
    for (int i = 0; i < 17; i++) begin
      rd16(8'(i * 4), v);
      check("R1 reset value", v, 0);
    end
  endtask

  task automatic t_plain;
    logic [15:0] v;
    logic [7:0] offs [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40};
    for (int i = 0; i < 8; i++) wr16(offs[i], 16'hA500 + 16'(i));
    for (int i = 0; i < 8; i++) begin
      rd16(offs[i], v);
      check("R2 plain write readback", v, 16'hA500 + 16'(i));
    end
    wr16(8'h30, 16'h0); wr16(8'h40, 16'h0);
  endtask

  task automatic t_alias;
    logic [15:0] v;
    for (int b = 0; b < 3; b++) begin
      logic [7:0] base = 8'(b * 16);
      wr16(base, 16'hF0F0);
      wr16(base + 8'h04, 16'h00FF);
      rd16(base, v); check("R3 clear alias", v, 16'hF000);
      wr16(base + 8'h08, 16'h000F);
      rd16(base, v); check("R4 set alias", v, 16'hF00F);
      wr16(base + 8'h0C, 16'hFFFF);
      rd16(base, v); check("R5 toggle alias", v, 16'h0FF0);
      for (int a = 1; a < 4; a++) begin
        rd16(base + 8'(a * 4), v);
        check("R6 alias read", v, 16'h0FF0);
      end
    end
  endtask

  task automatic t_errors;
    logic [15:0] d, v; logic e, vl;
    wr16(8'h00, 16'h1111);
    access(1'b1, 8'h00, 2'd0, 16'hFFFF, d, e, vl);
    check("R7 byte write err", e, 1);
    access(1'b1, 8'h10, 2'd2, 16'hFFFF, d, e, vl);
    check("R7 word write err", e, 1);
    access(1'b1, 8'h02, 2'd1, 16'hFFFF, d, e, vl);
    check("R7 misaligned err", e, 1);
    rd16(8'h00, v); check("R7 data unchanged", v, 16'h1111);
    access(1'b1, 8'h44, 2'd1, 16'hFFFF, d, e, vl);
    check("R8 out of map err", e, 1);
    access(1'b0, 8'hFC, 2'd1, 16'h0, d, e, vl);
    check("R8 read err", e, 1);
    check("R8 read err data", d, 0);
    rd16(8'h44, v); check("R8 read past map zero", v, 0);
    access(1'b0, 8'h00, 2'd1, 16'h0, d, e, vl);
    check("R9 good read no err", e, 0);
    check("R9 rsp_valid high", vl, 1);
    check("R9 read data", d, 16'h1111);
    @(negedge clk);
    check("R9 rsp_valid drops", rsp_valid, 0);
    access(1'b1, 8'h00, 2'd1, 16'h2222, d, e, vl);
    check("R9 write rdata zero", d, 0);
  endtask

  task automatic t_pins;
    logic [15:0] v;
    wr16(8'h30, 16'h0000); wr16(8'h40, 16'hFFFF); wr16(8'h00, 16'h0000);
    pin_event(4'd5, 1'b1);
    rd16(8'h00, v); check("R10 pin sets bit", v, 16'h0020);
    pin_event(4'd15, 1'b1);
    pin_event(4'd5, 1'b0);
    rd16(8'h00, v); check("R10 pin updates", v, 16'h8000);
    wr16(8'h30, 16'h0020);
    pin_event(4'd5, 1'b1);
    rd16(8'h00, v); check("R11 output pin ignored", v, 16'h8000);
    wr16(8'h40, 16'hFFF7);
    pin_event(4'd3, 1'b1);
    rd16(8'h00, v); check("R11 disabled input ignored", v, 16'h8000);
    wr16(8'h30, 16'h0000); wr16(8'h40, 16'hFFFF);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    wr16(8'h00, 16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_size = 2'd1; req_wdata = 16'h1234;
    pin_valid = 1'b1; pin_idx = 4'd0; pin_level = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; pin_valid = 1'b0;
    rd16(8'h00, v); check("R12 plain write beats pin", v, 16'h1234);
    wr16(8'h00, 16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h08; req_wdata = 16'h0100;
    pin_valid = 1'b1; pin_idx = 4'd0; pin_level = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; pin_valid = 1'b0;
    rd16(8'h00, v); check("R12 set alias beats pin", v, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_alias();
    t_errors();
    t_pins();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule